// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers eight interrupt request lines and presents one interrupt signal to a processor. Each line is synchronized to the clock, and a low-to-high transition on it latches a pending request. A per-line mask gates which pending requests may compete. The lowest-numbered eligible line wins. The controller also keeps a record of the lines currently being serviced. A new request raises the processor interrupt only when it outranks every line in service, so a more urgent source can preempt a less urgent handler.

The processor answers the interrupt with a one-cycle acknowledge pulse. The controller then returns an 8-bit vector built from a programmable base and the winning line number. At the same moment it moves that line from pending to in-service. Software uses a small write port to load the mask, load the vector base, and issue a non-specific end-of-interrupt command. That command retires the most urgent line in service.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset `int_out` is 0, `vec_out` is 0, the vector base is 0, no request is pending or in service, and every mask bit is clear (all lines enabled).
- R2: A request is latched only on a low-to-high transition of `irq_in[i]`. A line that stays high after its request has been acknowledged does not raise a new request.
- R3: A line whose mask bit is 1 cannot raise `int_out`. Masking does not discard a latched request. A mask write (`wr_sel`=0, `wr_data[7:0]`, bit i masks line i) affects `int_out` in the cycle after the write is sampled.
- R4: When several eligible requests are pending, the lowest-numbered line wins. Line 0 is the most urgent and line 7 the least.
- R5: In the cycle after `ack` is sampled high, `vec_out` equals {base[4:0], line[2:0]}. The base is loaded by a write with `wr_sel`=1 and is taken from `wr_data[7:3]`.
- R6: An acknowledge moves the winning line from pending to in-service. `int_out` then drops in the next cycle unless another eligible request outranks every in-service line.
- R7: `int_out` is 1 exactly when the most urgent unmasked pending line is more urgent than the most urgent in-service line, or when nothing is in service. A pending request of lower or equal urgency waits.
- R8: A write with `wr_sel`=2 (end of interrupt) clears the most urgent bit set in the in-service record. The effect on `int_out` appears in the next cycle.
- R9: An acknowledge that arrives while `int_out` is 0 returns {base, 3'b111} and changes neither the pending nor the in-service state.
- R10: `int_out` rises two cycles after the cycle in which the rising input is first sampled. An input pulse that is high for a single clock cycle is still latched.
- R11: A write with `wr_sel`=3 changes neither the mask nor the base nor the in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Asynchronous interrupt request lines, line 0 most urgent |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mask, 1 vector base, 2 end of interrupt, 3 none |
| wr_data | input | 8 | Write data |
| ack | input | 1 | One-cycle interrupt acknowledge from the processor |
| int_out | output | 1 | Registered interrupt request to the processor |
| vec_out | output | 8 | Registered vector number returned by the last acknowledge |

## Verification
Each result is due a fixed number of cycles after its stimulus. `int_out` follows a rising request line three clock edges after the bench drives it, because of two synchronizer stages and the pending register. The vector and the updated `int_out` appear one edge after an acknowledge. A mask, base or end-of-interrupt write shows its effect one edge after the write. Each stimulus task registers the expected result with the exact cycle number at which it is due. The monitor compares results only at the falling edge of that cycle, so no result is judged early or late.

// File: rtl/nirq_pkg.sv
package nirq_pkg;

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_BASE = 2'd1,
    SEL_EOI  = 2'd2,
    SEL_NONE = 2'd3
  } wr_target_e;

endpackage

// File: rtl/nirq_edge_det.sv
module nirq_edge_det #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] rise
);

  logic [N-1:0] chain [STAGES];
  logic [N-1:0] prev_q;

  // Synchronizer chain, one stage per generate iteration
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~prev_q;

endmodule

// File: rtl/nirq_prio_pick.sv
module nirq_prio_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     bits,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  // Lowest set index wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int NUM_LINES   = 8,
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [VEC_W-1:0]     wr_data,
  input  logic                 ack,
  output logic                 int_out,
  output logic [VEC_W-1:0]     vec_out
);
  import nirq_pkg::*;

  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int BASE_W = VEC_W - IDX_W;

  logic [NUM_LINES-1:0] irr_q, isr_q, mask_q;
  logic [BASE_W-1:0]    base_q;
  logic [NUM_LINES-1:0] rise;

  logic [NUM_LINES-1:0] irr_d, isr_d, mask_d, ack_clr, eoi_clr;
  logic                 req_hit, svc_hit, nreq_hit, nsvc_hit;
  logic [IDX_W-1:0]     req_idx, svc_idx, nreq_idx, nsvc_idx;
  logic                 grant, int_d;
  logic                 do_mask, do_base, do_eoi;

  nirq_edge_det #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) u_edge (
    .clk (clk),
    .rst (rst),
    .raw (irq_in),
    .rise(rise)
  );

  // Present-state arbitration
  nirq_prio_pick #(.N(NUM_LINES), .IDX_W(IDX_W)) u_req_now (
    .bits(irr_q & ~mask_q), .hit(req_hit), .idx(req_idx)
  );
  nirq_prio_pick #(.N(NUM_LINES), .IDX_W(IDX_W)) u_svc_now (
    .bits(isr_q), .hit(svc_hit), .idx(svc_idx)
  );

  assign grant   = req_hit && (!svc_hit || (req_idx < svc_idx));
  assign do_mask = wr_en && (wr_target_e'(wr_sel) == SEL_MASK);
  assign do_base = wr_en && (wr_target_e'(wr_sel) == SEL_BASE);
  assign do_eoi  = wr_en && (wr_target_e'(wr_sel) == SEL_EOI);

  always_comb begin
    ack_clr = '0;
    eoi_clr = '0;
    if (ack && grant)    ack_clr[req_idx] = 1'b1;
    if (do_eoi && svc_hit) eoi_clr[svc_idx] = 1'b1;
  end

  assign mask_d = do_mask ? wr_data[NUM_LINES-1:0] : mask_q;
  assign irr_d  = (irr_q & ~ack_clr) | rise;
  assign isr_d  = (isr_q & ~eoi_clr) | ack_clr;

  // Next-state arbitration drives the registered interrupt output
  nirq_prio_pick #(.N(NUM_LINES), .IDX_W(IDX_W)) u_req_nxt (
    .bits(irr_d & ~mask_d), .hit(nreq_hit), .idx(nreq_idx)
  );
  nirq_prio_pick #(.N(NUM_LINES), .IDX_W(IDX_W)) u_svc_nxt (
    .bits(isr_d), .hit(nsvc_hit), .idx(nsvc_idx)
  );

  assign int_d = nreq_hit && (!nsvc_hit || (nreq_idx < nsvc_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q   <= '0;
      isr_q   <= '0;
      mask_q  <= '0;
      base_q  <= '0;
      int_out <= 1'b0;
      vec_out <= '0;
    end else begin
      irr_q   <= irr_d;
      isr_q   <= isr_d;
      mask_q  <= mask_d;
      int_out <= int_d;
      if (do_base) base_q <= wr_data[VEC_W-1:IDX_W];
      if (ack)     vec_out <= {base_q, (grant ? req_idx : {IDX_W{1'b1}})};
    end
  end

endmodule

// File: rtl/nirq_ctrl_chk.sv
module nirq_ctrl_chk #(
  parameter int N     = 8,
  parameter int VEC_W = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ack,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             int_out,
  input logic [VEC_W-1:0] vec_out,
  input logic [N-1:0]     irr_q,
  input logic [N-1:0]     isr_q,
  input logic [N-1:0]     mask_q
);

  logic eoi_wr;
  assign eoi_wr = wr_en && (wr_sel == 2'd2);

  AST_INT_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    int_out |-> ((irr_q & ~mask_q) != '0)); // R3

  AST_ACK_MARKS_SERVICE: assert property (@(posedge clk) disable iff (rst)
    (ack && int_out) |=> isr_q[vec_out[IDX_W-1:0]]); // R6

  AST_ACK_GROWS_SERVICE: assert property (@(posedge clk) disable iff (rst)
    (ack && int_out && !eoi_wr) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1)); // R6

  AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (rst)
    (eoi_wr && (isr_q != '0) && !ack) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1)); // R8

  AST_SPURIOUS_CODE: assert property (@(posedge clk) disable iff (rst)
    (ack && !int_out) |=> (vec_out[IDX_W-1:0] == {IDX_W{1'b1}})); // R9

  AST_SPURIOUS_KEEPS_SERVICE: assert property (@(posedge clk) disable iff (rst)
    (ack && !int_out && !wr_en) |=> $stable(isr_q)); // R9

endmodule

bind nest_irq_ctrl nirq_ctrl_chk #(
  .N(NUM_LINES), .VEC_W(VEC_W), .IDX_W(IDX_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .ack    (ack),
  .wr_en  (wr_en),
  .wr_sel (wr_sel),
  .int_out(int_out),
  .vec_out(vec_out),
  .irr_q  (irr_q),
  .isr_q  (isr_q),
  .mask_q (mask_q)
);

// File: tb/nest_irq_ctrl_test.sv
module nest_irq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       ack = 1'b0;
  logic       int_out;
  logic [7:0] vec_out;

  int  cyc = 0;
  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  typedef struct {
    int         due;
    bit         chk_vec;
    logic       int_e;
    logic [7:0] vec_e;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nest_irq_ctrl uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ack(ack), .int_out(int_out), .vec_out(vec_out)
  );

  // Monitor: compare due items at the falling edge
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        checks++;
        if (int_out !== sb[i].int_e) begin
          errors++;
          $display("FAIL %s cycle %0d: int_out=%b expected %b", sb[i].tag, cyc, int_out, sb[i].int_e);
        end
        if (sb[i].chk_vec) begin
          checks++;
          if (vec_out !== sb[i].vec_e) begin
            errors++;
            $display("FAIL %s cycle %0d: vec_out=%h expected %h", sb[i].tag, cyc, vec_out, sb[i].vec_e);
          end
        end
        sb.delete(i);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic step(input int n);
    repeat (n) tick();
  endtask

  task automatic expect_at(input int off, input logic ie, input bit cv, input logic [7:0] ve, input string tag);
    exp_t e;
    e.due = cyc + off; e.chk_vec = cv; e.int_e = ie; e.vec_e = ve; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic set_irq(input logic [7:0] val, input logic ie, input string tag);
    irq_in = val;
    expect_at(3, ie, 1'b0, 8'h00, tag);
    step(4);
  endtask

  task automatic do_ack(input logic ie, input logic [7:0] ve, input string tag);
    ack = 1'b1;
    expect_at(1, ie, 1'b1, ve, tag);
    tick();
    ack = 1'b0;
  endtask

  task automatic do_wr(input logic [1:0] sel, input logic [7:0] data, input logic ie, input string tag);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    expect_at(1, ie, 1'b0, 8'h00, tag);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      if (sb.size() != 0) begin
        errors++;
        $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run not complete, expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst = 1'b0;
    expect_at(0, 1'b0, 1'b1, 8'h00, "R1");
    expect_at(1, 1'b0, 1'b1, 8'h00, "R1");
    step(2);

    // R10 latency, R1 all lines enabled after reset
    expect_at(2, 1'b0, 1'b0, 8'h00, "R10");
    set_irq(8'h08, 1'b1, "R10");
    do_ack(1'b0, 8'h03, "R5");
    expect_at(4, 1'b0, 1'b0, 8'h00, "R2");
    step(5);

    // R7 nesting: line 1 preempts line 3
    set_irq(8'h0A, 1'b1, "R7");
    do_ack(1'b0, 8'h01, "R6");
    set_irq(8'h2A, 1'b0, "R7");
    expect_at(1, 1'b0, 1'b0, 8'h00, "R7");
    step(3);

    // R8 end of interrupt retires the most urgent first
    do_wr(2'd2, 8'h00, 1'b0, "R8");
    do_wr(2'd2, 8'h00, 1'b1, "R8");
    do_ack(1'b0, 8'h05, "R5");
    do_wr(2'd2, 8'h00, 1'b0, "R8");

    // R3 mask holds a latched request
    set_irq(8'h00, 1'b0, "R2");
    do_wr(2'd0, 8'h01, 1'b0, "R3");
    set_irq(8'h01, 1'b0, "R3");
    do_wr(2'd0, 8'h00, 1'b1, "R3");
    do_wr(2'd1, 8'hA8, 1'b1, "R5");
    do_ack(1'b0, 8'hA8, "R5");
    do_wr(2'd2, 8'h00, 1'b0, "R8");

    // R4 simultaneous requests
    set_irq(8'h00, 1'b0, "R4");
    set_irq(8'h90, 1'b1, "R4");
    do_ack(1'b0, 8'hAC, "R4");
    do_wr(2'd2, 8'h00, 1'b1, "R8");
    do_ack(1'b0, 8'hAF, "R4");
    do_wr(2'd2, 8'h00, 1'b0, "R8");

    // R9 acknowledge with nothing eligible
    do_wr(2'd1, 8'h40, 1'b0, "R9");
    do_wr(2'd0, 8'h40, 1'b0, "R9");
    set_irq(8'h00, 1'b0, "R9");
    set_irq(8'h40, 1'b0, "R3");
    do_ack(1'b0, 8'h47, "R9");
    do_wr(2'd0, 8'h00, 1'b1, "R9");
    do_ack(1'b0, 8'h46, "R9");
    do_wr(2'd2, 8'h00, 1'b0, "R8");

    // R11 unused write target
    do_wr(2'd3, 8'hFF, 1'b0, "R11");
    set_irq(8'h00, 1'b0, "R11");
    set_irq(8'h01, 1'b1, "R11");
    do_ack(1'b0, 8'h40, "R11");
    do_wr(2'd2, 8'h00, 1'b0, "R8");

    // R10 single-cycle pulse
    set_irq(8'h00, 1'b0, "R10");
    irq_in = 8'h04;
    expect_at(3, 1'b1, 1'b0, 8'h00, "R10");
    tick();
    irq_in = 8'h00;
    step(3);
    do_ack(1'b0, 8'h42, "R10");
    do_wr(2'd2, 8'h00, 1'b0, "R8");

    step(3);
    finish_run();
  end

endmodule